// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects a set of level-sensitive device request lines and one non-maskable request. It brings them into the processor clock domain and filters the maskable lines through a per-line enable register. It then picks a single winner by fixed priority. The highest line index wins, and the non-maskable line outranks every line. A maskable winner reaches the processor only if its priority is strictly above the processor's current level. The processor interrupt output can rise only on the cycle that follows an instruction-boundary strobe.

When the processor answers with an acknowledge, the block arbitrates again on the current synchronized state. If there is a winner, it returns that winner's vector and pulses an acknowledge back to the chosen device so the device can drop its line. Maskable line `i` gets the vector `vec_base + 4*i`. The non-maskable source gets the fixed vector `NMI_VECTOR`. If nothing eligible is active at acknowledge time, the block raises a spurious flag instead of a vector.

Top module: `vec_irq_ctrl`

## Requirements
- R1: While `rst` is high, and on the first cycle after it is released, `cpu_irq`, `vec_valid`, `spurious`, `nmi_ack` and all of `dev_ack` are low. Every maskable line comes out of reset disabled.
- R2: Every request input passes through two flip-flops, and `cpu_irq` is registered. Take a request that rises before clock edge k, with `insn_boundary` high, the line enabled and nothing else pending. `cpu_irq` stays low after edges k and k+1 and is high after edge k+2.
- R3: A maskable line whose enable is off never raises `cpu_irq`, never produces a vector and never gets a `dev_ack`. `mask_we` loads `mask_wdata` on the next edge. With the default `MASK_BIT_ENABLES=1`, bit i set enables line i. With 0, bit i set disables it.
- R4: `nmi_req` ignores both the mask and `cur_level`, and it outranks every maskable line. Its acknowledge returns `NMI_VECTOR` and a one-cycle `nmi_ack`.
- R5: Among the eligible maskable lines, the one with the highest index is selected.
- R6: Line i has priority i+1. It is eligible only when i+1 is strictly greater than `cur_level`.
- R7: `cpu_irq` is high in a cycle only if `insn_boundary` was high at the edge that opened that cycle and a source was pending then.
- R8: In the cycle after `cpu_ack` is sampled high with a winner present, `vec_valid` is high for one cycle. `vec_out` then equals `vec_base + 4*i` for line i, or `NMI_VECTOR` for the non-maskable source.
- R9: In that same cycle, exactly one acknowledge is pulsed: bit i of `dev_ack` for line i, or `nmi_ack` for the non-maskable source. Otherwise all acknowledges are low.
- R10: If `cpu_acknowledge` finds no eligible active source, then in the next cycle `spurious` is high for one cycle. In that cycle `vec_valid`, `nmi_ack` and every `dev_ack` stay low.
- R11: `cpu_irq` is low in the cycle after `cpu_ack` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | NUM_SRC | Asynchronous level device requests |
| nmi_req | input | 1 | Asynchronous non-maskable request |
| mask_we | input | 1 | Mask register write strobe |
| mask_wdata | input | NUM_SRC | Mask register write data |
| vec_base | input | VEC_W | Base address for maskable vectors |
| cur_level | input | LVL_W | Current processor priority level |
| insn_boundary | input | 1 | High at an instruction boundary |
| cpu_irq | output | 1 | Interrupt request to the processor |
| cpu_ack | input | 1 | Processor acknowledge |
| vec_out | output | VEC_W | Vector of the acknowledged source |
| vec_valid | output | 1 | `vec_out` is valid this cycle |
| spurious | output | 1 | Acknowledge found no source |
| dev_ack | output | NUM_SRC | One-hot acknowledge to a device |
| nmi_ack | output | 1 | Acknowledge to the non-maskable source |

## Verification
The bench targets the points where an off-by-one or an inverted test hides. It checks the exact three-edge latency, where an extra or missing sync stage shifts `cpu_irq` by a cycle. It checks a line sitting exactly at `cur_level`, where a non-strict compare would let it through. It checks two simultaneous lines, where a reversed encoder would vector the lower one. It also checks a masked line and an acknowledge taken after the source has gone away. A design that got either of those last two wrong would vector a dead line instead of flagging it spurious. Finally, the non-maskable line is driven with all lines masked and the level at its maximum, which catches a design that gates it wrongly. A behavioural model tracks all of this cycle by cycle through a long random phase.

// File: rtl/irq_pkg.sv
package irq_pkg;
  // outcome of an acknowledge cycle
  typedef enum logic [1:0] {
    ACK_NONE = 2'd0,
    ACK_DEV  = 2'd1,
    ACK_NMI  = 2'd2,
    ACK_SPUR = 2'd3
  } ack_kind_t;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int WIDTH  = 9,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[s] <= '0;
      else if (s == 0) stg[s] <= din;
      else stg[s] <= stg[(s == 0) ? 0 : s-1];
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int WIDTH            = 8,
  parameter bit MASK_BIT_ENABLES = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] line_en
);
  localparam logic [WIDTH-1:0] RESET_VAL = MASK_BIT_ENABLES ? '0 : '1;
  logic [WIDTH-1:0] mask_q;

  always_ff @(posedge clk) begin
    if (rst)     mask_q <= RESET_VAL;
    else if (we) mask_q <= wdata;
  end

  if (MASK_BIT_ENABLES) begin : g_pos
    assign line_en = mask_q;
  end else begin : g_neg
    assign line_en = ~mask_q;
  end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int WIDTH = 8,
  parameter int IDX_W = 3,
  parameter int LVL_W = 4
) (
  input  logic [WIDTH-1:0] active,
  input  logic [LVL_W-1:0] level,
  output logic             hit,
  output logic [IDX_W-1:0] idx
);
  logic [WIDTH-1:0] elig;

  for (genvar i = 0; i < WIDTH; i++) begin : g_gate
    localparam logic [LVL_W-1:0] PRIO = LVL_W'(i + 1);
    assign elig[i] = active[i] && (PRIO > level);
  end

  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = 0; i < WIDTH; i++) begin
      if (elig[i]) begin
        hit = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl #(
  parameter int              NUM_SRC          = 8,
  parameter int              VEC_W            = 16,
  parameter int              SYNC_STAGES      = 2,
  parameter bit              MASK_BIT_ENABLES = 1'b1,
  parameter logic [VEC_W-1:0] NMI_VECTOR      = 16'hFFF0,
  localparam int             LVL_W            = $clog2(NUM_SRC + 1),
  localparam int             IDX_W            = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] irq_req,
  input  logic               nmi_req,
  input  logic               mask_we,
  input  logic [NUM_SRC-1:0] mask_wdata,
  input  logic [VEC_W-1:0]   vec_base,
  input  logic [LVL_W-1:0]   cur_level,
  input  logic               insn_boundary,
  output logic               cpu_irq,
  input  logic               cpu_ack,
  output logic [VEC_W-1:0]   vec_out,
  output logic               vec_valid,
  output logic               spurious,
  output logic [NUM_SRC-1:0] dev_ack,
  output logic               nmi_ack
);
  import irq_pkg::*;

  logic [NUM_SRC:0]   req_s;
  logic [NUM_SRC-1:0] line_en;
  logic [NUM_SRC-1:0] act;
  logic               nmi_s;
  logic               hit;
  logic [IDX_W-1:0]   win_idx;
  logic               pend;
  ack_kind_t          kind;
  logic [NUM_SRC-1:0] dev_ack_d;

  irq_sync #(.WIDTH(NUM_SRC + 1), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .din ({nmi_req, irq_req}),
    .dout(req_s)
  );

  irq_mask_reg #(.WIDTH(NUM_SRC), .MASK_BIT_ENABLES(MASK_BIT_ENABLES)) u_mask (
    .clk    (clk),
    .rst    (rst),
    .we     (mask_we),
    .wdata  (mask_wdata),
    .line_en(line_en)
  );

  assign act   = req_s[NUM_SRC-1:0] & line_en;
  assign nmi_s = req_s[NUM_SRC];

  irq_prio_pick #(.WIDTH(NUM_SRC), .IDX_W(IDX_W), .LVL_W(LVL_W)) u_pick (
    .active(act),
    .level (cur_level),
    .hit   (hit),
    .idx   (win_idx)
  );

  assign pend = nmi_s | hit;

  always_comb begin
    if (!cpu_ack)   kind = ACK_NONE;
    else if (nmi_s) kind = ACK_NMI;
    else if (hit)   kind = ACK_DEV;
    else            kind = ACK_SPUR;
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_dack
    assign dev_ack_d[i] = (kind == ACK_DEV) && (win_idx == IDX_W'(i));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_irq   <= 1'b0;
      vec_valid <= 1'b0;
      spurious  <= 1'b0;
      nmi_ack   <= 1'b0;
      dev_ack   <= '0;
      vec_out   <= '0;
    end else begin
      cpu_irq   <= insn_boundary & pend & ~cpu_ack;
      vec_valid <= (kind == ACK_DEV) || (kind == ACK_NMI);
      spurious  <= (kind == ACK_SPUR);
      nmi_ack   <= (kind == ACK_NMI);
      dev_ack   <= dev_ack_d;
      if (kind == ACK_NMI)      vec_out <= NMI_VECTOR;
      else if (kind == ACK_DEV) vec_out <= vec_base + (VEC_W'(win_idx) << 2);
    end
  end
endmodule

// File: rtl/irq_ctrl_checker.sv
module irq_ctrl_checker #(
  parameter int NUM_SRC = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               insn_boundary,
  input logic               cpu_irq,
  input logic               cpu_ack,
  input logic               vec_valid,
  input logic               spurious,
  input logic [NUM_SRC-1:0] dev_ack,
  input logic               nmi_ack,
  input logic [NUM_SRC-1:0] line_en
);
  assert_ack_onehot_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({dev_ack, nmi_ack}));

  assert_spur_alone_R10: assert property (@(posedge clk) disable iff (rst)
    spurious |-> (!vec_valid && !nmi_ack && dev_ack == '0));

  assert_irq_boundary_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(cpu_irq) |-> $past(insn_boundary));

  assert_irq_drop_R11: assert property (@(posedge clk) disable iff (rst)
    cpu_ack |=> !cpu_irq);

  assert_valid_follows_ack_R8: assert property (@(posedge clk) disable iff (rst)
    (vec_valid || spurious) |-> $past(cpu_ack));

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_mask_chk
    assert_masked_no_ack_R3: assert property (@(posedge clk) disable iff (rst)
      $rose(dev_ack[i]) |-> $past(line_en[i]));
  end
endmodule

bind vec_irq_ctrl irq_ctrl_checker #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .insn_boundary(insn_boundary),
  .cpu_irq      (cpu_irq),
  .cpu_ack      (cpu_ack),
  .vec_valid    (vec_valid),
  .spurious     (spurious),
  .dev_ack      (dev_ack),
  .nmi_ack      (nmi_ack),
  .line_en      (line_en)
);

// File: tb/vec_irq_ctrl_test.sv
module vec_irq_ctrl_test;
  localparam int N = 8;
  localparam int VW = 16;
  localparam int LW = 4;
  localparam logic [VW-1:0] NMI_V = 16'hFFF0;
  localparam logic [VW-1:0] BASE  = 16'h1000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] irq_req = '0;
  logic nmi_req = 1'b0, mask_we = 1'b0, insn_boundary = 1'b0, cpu_ack = 1'b0;
  logic [N-1:0] mask_wdata = '0;
  logic [VW-1:0] vec_base = BASE;
  logic [LW-1:0] cur_level = '0;
  logic cpu_irq, vec_valid, spurious, nmi_ack;
  logic [VW-1:0] vec_out;
  logic [N-1:0] dev_ack;

  int checks = 0, failures = 0;

  always #5 clk = ~clk;

  vec_irq_ctrl uut (
    .clk(clk), .rst(rst), .irq_req(irq_req), .nmi_req(nmi_req),
    .mask_we(mask_we), .mask_wdata(mask_wdata), .vec_base(vec_base),
    .cur_level(cur_level), .insn_boundary(insn_boundary), .cpu_irq(cpu_irq),
    .cpu_ack(cpu_ack), .vec_out(vec_out), .vec_valid(vec_valid),
    .spurious(spurious), .dev_ack(dev_ack), .nmi_ack(nmi_ack)
  );

  // behavioural reference model
  logic [N:0]    m_d1, m_d2;
  logic [N-1:0]  m_mask;
  logic          e_irq, e_valid, e_spur, e_nmi;
  logic [N-1:0]  e_dack;
  logic [VW-1:0] e_vec;

  always @(posedge clk) begin
    if (rst) begin
      m_d1 <= '0; m_d2 <= '0; m_mask <= '0;
      e_irq <= 0; e_valid <= 0; e_spur <= 0; e_nmi <= 0; e_dack <= '0; e_vec <= '0;
    end else begin
      int best;
      best = -1;
      for (int i = 0; i < N; i++)
        if (m_d2[i] && m_mask[i] && (i + 1 > int'(cur_level))) best = i;
      e_irq   <= insn_boundary && !cpu_ack && (m_d2[N] || best >= 0);
      e_nmi   <= cpu_ack && m_d2[N];
      e_valid <= cpu_ack && (m_d2[N] || best >= 0);
      e_spur  <= cpu_ack && !m_d2[N] && best < 0;
      e_dack  <= (cpu_ack && !m_d2[N] && best >= 0) ? (N'(1) << best) : '0;
      if (cpu_ack && m_d2[N]) e_vec <= NMI_V;
      else if (cpu_ack && best >= 0) e_vec <= BASE + VW'(best * 4);
      m_d1 <= {nmi_req, irq_req};
      m_d2 <= m_d1;
      if (mask_we) m_mask <= mask_wdata;
    end
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      chk("R7 cpu_irq model", cpu_irq, e_irq);
      chk("R8 vec_valid model", vec_valid, e_valid);
      if (e_valid) chk("R8 vec_out model", vec_out, e_vec);
      chk("R10 spurious model", spurious, e_spur);
      chk("R9 dev_ack model", dev_ack, e_dack);
      chk("R4 nmi_ack model", nmi_ack, e_nmi);
    end
  end

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_mask(input logic [N-1:0] m);
    mask_wdata = m; mask_we = 1'b1; tick(); mask_we = 1'b0;
  endtask

  task automatic do_ack();
    cpu_ack = 1'b1; tick(); cpu_ack = 1'b0;
  endtask

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    tick(3);
    chk("R1 reset cpu_irq", cpu_irq, 0);
    chk("R1 reset acks", {vec_valid, spurious, nmi_ack, dev_ack}, 0);
    rst = 1'b0;
    // R1: lines disabled after reset
    insn_boundary = 1'b1; irq_req = 8'h10; tick(4);
    chk("R1 masked after reset", cpu_irq, 0);
    irq_req = '0; tick(3);

    // R2: three-edge latency
    write_mask(8'hFF); tick(3);
    irq_req[3] = 1'b1; tick();
    chk("R2 edge1", cpu_irq, 0); tick();
    chk("R2 edge2", cpu_irq, 0); tick();
    chk("R2 edge3", cpu_irq, 1);
    do_ack();
    chk("R8 vector line3", vec_out, BASE + 16'd12);
    chk("R9 dev_ack line3", dev_ack, 8'h08);
    chk("R11 irq drops on ack", cpu_irq, 0);
    irq_req = '0; tick(3);

    // R5: two lines, higher index wins
    irq_req = 8'h42; tick(3);
    do_ack();
    chk("R5 priority vector", vec_out, BASE + 16'd24);
    chk("R5 priority ack", dev_ack, 8'h40);
    irq_req = '0; tick(3);

    // R6: strict level compare
    irq_req = 8'h40; cur_level = 4'd6; tick(3);
    chk("R6 prio7 above level6", cpu_irq, 1);
    cur_level = 4'd7; tick(2);
    chk("R6 prio7 at level7 blocked", cpu_irq, 0);
    do_ack();
    chk("R10 spurious at level", spurious, 1);
    chk("R10 no vector", vec_valid, 0);
    irq_req = 8'h80; tick(3);
    chk("R6 prio8 above level7", cpu_irq, 1);
    irq_req = '0; cur_level = '0; tick(3);

    // R3: masked line ignored
    write_mask(8'hBF); irq_req = 8'h40; tick(4);
    chk("R3 masked no irq", cpu_irq, 0);
    do_ack();
    chk("R3 masked no dev_ack", dev_ack, 0);
    chk("R10 masked spurious", spurious, 1);
    irq_req = '0; tick(3);

    // R10: source gone before acknowledge
    write_mask(8'hFF); irq_req = 8'h04; tick(3);
    chk("R10 pending before drop", cpu_irq, 1);
    irq_req = '0; tick(2);
    do_ack();
    chk("R10 late ack spurious", spurious, 1);

    // R4: NMI ignores mask and level
    write_mask(8'h00); cur_level = 4'd8; irq_req = 8'hFF; nmi_req = 1'b1; tick(3);
    chk("R4 nmi raises irq", cpu_irq, 1);
    do_ack();
    chk("R4 nmi vector", vec_out, NMI_V);
    chk("R4 nmi_ack", nmi_ack, 1);
    chk("R4 no dev_ack", dev_ack, 0);
    nmi_req = 1'b0; irq_req = '0; cur_level = '0; tick(3);

    // R7: boundary gating
    write_mask(8'hFF); insn_boundary = 1'b0; irq_req = 8'h01; tick(5);
    chk("R7 no boundary no irq", cpu_irq, 0);
    insn_boundary = 1'b1; tick();
    chk("R7 boundary raises irq", cpu_irq, 1);
    irq_req = '0; tick(3);

    // random phase, compared against the model each cycle
    for (int k = 0; k < 4000; k++) begin
      irq_req       = ($urandom_range(0, 7) == 0) ? N'($urandom) : irq_req;
      nmi_req       = ($urandom_range(0, 31) == 0) ? ~nmi_req : nmi_req;
      insn_boundary = $urandom_range(0, 2) != 0;
      cpu_ack       = $urandom_range(0, 5) == 0;
      cur_level     = ($urandom_range(0, 15) == 0) ? LW'($urandom_range(0, 8)) : cur_level;
      mask_we       = $urandom_range(0, 40) == 0;
      mask_wdata    = N'($urandom);
      tick();
    end
    cpu_ack = 1'b0; mask_we = 1'b0; tick(2);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule